// File: doc/BRIEF.md
# Per-Channel Interrupt Status Unit

This unit collects the event reports of a two-channel transfer controller and turns them into one interrupt request. Each channel has an 8-bit slice of a 32-bit status word, with five defined causes: transfer command finished, receive overflow, transmit underflow, poll timeout and invalid control. The event logic reports a cause with a single-cycle pulse, and the unit keeps it in a sticky status bit until software clears that bit by writing a one to it.

Software reads the raw status, a mask register and a read-only view of the status ANDed with the mask, all through one simple register port. The port has an address, a write strobe, write data and combinational read data. The interrupt output is a registered OR of the masked view. An interrupt handler reads the masked view to see whether the request is its own, writes the clear-all value to the status word, and rewrites the mask.

Top module: `chirq_unit`

## Requirements
- R1: An event pulse on `evt_pulse_i[c*5+e]` sets status bit `c*8+e` at the next rising clock edge. The event index e is 0 for command done, 1 for receive overflow, 2 for transmit underflow, 3 for poll timeout and 4 for invalid control. The bit stays set with no further pulse.
- R2: A write to offset 0x08 clears each status bit whose write-data bit is 1 and leaves the bits written with 0 unchanged.
- R3: When a set pulse and a clearing write hit the same status bit in one cycle, the bit ends up set.
- R4: The mask register at offset 0x10 is loaded with the write data on every write to it. Only the implemented bits 0x00001F1F are kept.
- R5: Offset 0x0C reads the raw status ANDed with the mask. Writes to 0x0C change neither the status nor the mask.
- R6: `irq_o` is high in the cycle after the masked status is nonzero and low in the cycle after it is zero. It therefore lags the registers by one clock.
- R7: Status and mask bits outside 0x00001F1F always read 0, and writes to them have no effect. Writing 0xFF001F1F to offset 0x08 clears every status bit.
- R8: After reset the status, the mask and `irq_o` are all zero.
- R9: Reads from any offset other than 0x08, 0x0C and 0x10 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_pulse_i | input | 10 | Single-cycle event pulses, channel c event e at index c*5+e |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wr_i | input | 1 | Write strobe for the addressed register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i, combinational |
| irq_o | output | 1 | Registered interrupt request |

## Verification
The hardest case to reach from the ports is a clearing write that lands on the same edge as an event pulse for the same bit. The bench places the pulse and the write-one in one vector so that both are driven in one clock cycle, then reads the status back. A second hard case is the one-cycle lag of `irq_o`. A directed test samples the output both on the edge that sets the status and on the edge after it. Writes to the read-only view and to unimplemented bits are each followed by a read of the register they could have disturbed.

// File: rtl/chirq_pkg.sv
`timescale 1ns/1ps
package chirq_pkg;
   // register byte offsets decoded by software
   localparam int unsigned OFS_STATUS = 32'h08;
   localparam int unsigned OFS_MASKED = 32'h0C;
   localparam int unsigned OFS_MASK   = 32'h10;

   // bit map of the implemented status bits
   function automatic logic [31:0] impl_bits(int unsigned n_ch, int unsigned slice_w,
                                             int unsigned n_evt);
      logic [31:0] m;
      m = '0;
      for (int unsigned c = 0; c < n_ch; c++)
         for (int unsigned e = 0; e < n_evt; e++)
            m[c*slice_w + e] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/chirq_status_slice.sv
`timescale 1ns/1ps
module chirq_status_slice #(
   parameter int unsigned N_EVT = 5
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [N_EVT-1:0] set_i,
   input  logic [N_EVT-1:0] clr_i,
   output logic [N_EVT-1:0] status_o
);
   logic [N_EVT-1:0] status_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) status_q <= '0;
      else         status_q <= (status_q & ~clr_i) | set_i;
   end

   assign status_o = status_q;

   // R3
   set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i != '0) |=> ((status_q & $past(set_i)) == $past(set_i)));

   // R2
   clr_takes_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((clr_i & ~set_i) != '0) |=> ((status_q & $past(clr_i & ~set_i)) == '0));
endmodule

// File: rtl/chirq_mask_reg.sv
`timescale 1ns/1ps
module chirq_mask_reg #(
   parameter int unsigned DATA_W = 32,
   parameter logic [DATA_W-1:0] IMPL = '1
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              wr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] mask_o
);
   logic [DATA_W-1:0] mask_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)   mask_q <= '0;
      else if (wr_i) mask_q <= wdata_i & IMPL;
   end

   assign mask_o = mask_q;

   // R4
   mask_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wr_i |=> (mask_q == $past(wdata_i & IMPL)));
endmodule

// File: rtl/chirq_read_mux.sv
`timescale 1ns/1ps
module chirq_read_mux
   import chirq_pkg::*;
#(
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32
) (
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] status_i,
   input  logic [DATA_W-1:0] masked_i,
   input  logic [DATA_W-1:0] mask_i,
   output logic [DATA_W-1:0] rdata_o
);
   always_comb begin
      rdata_o = '0;
      if (addr_i == ADDR_W'(OFS_STATUS))      rdata_o = status_i;
      else if (addr_i == ADDR_W'(OFS_MASKED)) rdata_o = masked_i;
      else if (addr_i == ADDR_W'(OFS_MASK))   rdata_o = mask_i;
   end
endmodule

// File: rtl/chirq_unit.sv
`timescale 1ns/1ps
module chirq_unit
   import chirq_pkg::*;
#(
   parameter int unsigned N_CH    = 2,
   parameter int unsigned SLICE_W = 8,
   parameter int unsigned N_EVT   = 5,
   parameter int unsigned ADDR_W  = 8,
   parameter int unsigned DATA_W  = 32
) (
   input  logic                   clk_i,
   input  logic                   rst_ni,
   input  logic [N_CH*N_EVT-1:0]  evt_pulse_i,
   input  logic [ADDR_W-1:0]      reg_addr_i,
   input  logic                   reg_wr_i,
   input  logic [DATA_W-1:0]      reg_wdata_i,
   output logic [DATA_W-1:0]      reg_rdata_o,
   output logic                   irq_o
);
   localparam logic [DATA_W-1:0] IMPL = DATA_W'(impl_bits(N_CH, SLICE_W, N_EVT));

   logic              wr_status, wr_mask;
   logic [N_EVT-1:0]  slice_st [N_CH];
   logic [DATA_W-1:0] status_w, mask_w, masked_w;
   logic              irq_q;

   assign wr_status = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_STATUS));
   assign wr_mask   = reg_wr_i && (reg_addr_i == ADDR_W'(OFS_MASK));

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      chirq_status_slice #(.N_EVT(N_EVT)) slice_i (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .set_i   (evt_pulse_i[c*N_EVT +: N_EVT]),
         .clr_i   (wr_status ? reg_wdata_i[c*SLICE_W +: N_EVT] : '0),
         .status_o(slice_st[c])
      );
   end

   always_comb begin
      status_w = '0;
      for (int c = 0; c < N_CH; c++)
         status_w[c*SLICE_W +: N_EVT] = slice_st[c];
   end

   chirq_mask_reg #(.DATA_W(DATA_W), .IMPL(IMPL)) mask_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (wr_mask),
      .wdata_i(reg_wdata_i),
      .mask_o (mask_w)
   );

   assign masked_w = status_w & mask_w;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b0;
      else         irq_q <= |masked_w;
   end
   assign irq_o = irq_q;

   chirq_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) rmux_i (
      .addr_i  (reg_addr_i),
      .status_i(status_w),
      .masked_i(masked_w),
      .mask_i  (mask_w),
      .rdata_o (reg_rdata_o)
   );

   // R6
   irq_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rst_ni |=> (irq_o == $past(|(status_w & mask_w))));

   // R8
   irq_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (mask_w == '0) |=> !irq_o);
endmodule

// File: tb/chirq_unit_tb.sv
`timescale 1ns/1ps
module chirq_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [9:0]  pulse = '0;
   logic [7:0]  addr = '0;
   logic        wr = 1'b0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;

   int n_vec = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   chirq_unit dut_i (
      .clk_i(clk), .rst_ni(rst_n), .evt_pulse_i(pulse),
      .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
      .reg_rdata_o(rdata), .irq_o(irq)
   );

   typedef struct packed {
      logic        wr;
      logic [7:0]  addr;
      logic [31:0] wdata;
      logic [9:0]  pulse;
      logic [7:0]  chk;
      logic [31:0] exp;
      logic        exp_irq;
      logic [3:0]  req;
   } vec_t;

   localparam int NV = 15;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 8'h00, 32'h0,        10'h001, 8'h08, 32'h00000001, 1'b0, 4'd1}, // R1 ch0 done
      '{1'b0, 8'h00, 32'h0,        10'h200, 8'h08, 32'h00001001, 1'b0, 4'd1}, // R1 ch1 invalid ctl
      '{1'b0, 8'h00, 32'h0,        10'h00E, 8'h08, 32'h0000100F, 1'b0, 4'd1}, // R1 ch0 e1..e3
      '{1'b1, 8'h10, 32'hFFFFFFFF, 10'h000, 8'h10, 32'h00001F1F, 1'b1, 4'd4}, // R4 mask load
      '{1'b0, 8'h00, 32'h0,        10'h000, 8'h0C, 32'h0000100F, 1'b1, 4'd5}, // R5 masked view
      '{1'b1, 8'h0C, 32'hFFFFFFFF, 10'h000, 8'h08, 32'h0000100F, 1'b1, 4'd5}, // R5 write ignored
      '{1'b1, 8'h08, 32'h00000003, 10'h000, 8'h08, 32'h0000100C, 1'b1, 4'd2}, // R2 w1c
      '{1'b1, 8'h10, 32'h00001000, 10'h000, 8'h0C, 32'h00001000, 1'b1, 4'd4}, // R4 narrow mask
      '{1'b1, 8'h08, 32'h00001000, 10'h200, 8'h08, 32'h0000100C, 1'b1, 4'd3}, // R3 set wins
      '{1'b1, 8'h08, 32'hFF001F1F, 10'h000, 8'h08, 32'h00000000, 1'b0, 4'd7}, // R7 clear all
      '{1'b0, 8'h00, 32'h0,        10'h020, 8'h0C, 32'h00000000, 1'b0, 4'd6}, // R6 masked out
      '{1'b1, 8'h10, 32'h00000100, 10'h000, 8'h0C, 32'h00000100, 1'b1, 4'd6}, // R6 unmask
      '{1'b0, 8'h14, 32'h0,        10'h000, 8'h14, 32'h00000000, 1'b1, 4'd9}, // R9 unmapped
      '{1'b1, 8'h08, 32'h0000E0E0, 10'h000, 8'h08, 32'h00000100, 1'b1, 4'd7}, // R7 unimpl bits
      '{1'b1, 8'h08, 32'h00000100, 10'h000, 8'h08, 32'h00000000, 1'b0, 4'd2}  // R2 last clear
   };

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      n_vec++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %08h expected %08h", req, got, exp);
      end
   endtask

   task automatic read_at(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      wr = 1'b0; pulse = '0; addr = a;
      #1 d = rdata;
   endtask

   initial begin
      logic [31:0] d;
      repeat (3) @(negedge clk);
      // R8 reset state
      check("R8 irq", {31'b0, irq}, 32'h0);
      read_at(8'h08, d); check("R8 status", d, 32'h0);
      read_at(8'h10, d); check("R8 mask", d, 32'h0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         wr = VECS[i].wr; addr = VECS[i].addr; wdata = VECS[i].wdata; pulse = VECS[i].pulse;
         @(negedge clk);
         wr = 1'b0; pulse = '0; addr = VECS[i].chk;
         @(posedge clk); #1;
         check($sformatf("R%0d vec %0d data", VECS[i].req, i), rdata, VECS[i].exp);
         check($sformatf("R%0d vec %0d irq", VECS[i].req, i), {31'b0, irq}, {31'b0, VECS[i].exp_irq});
      end

      // R6 one-cycle lag
      @(negedge clk); wr = 1'b1; addr = 8'h10; wdata = 32'h1;
      @(negedge clk); wr = 1'b0; addr = 8'h08; pulse = 10'h001;
      @(posedge clk); #1;
      check("R6 status on set edge", rdata, 32'h1);
      check("R6 irq not yet", {31'b0, irq}, 32'h0);
      @(negedge clk); pulse = '0;
      @(posedge clk); #1;
      check("R6 irq one cycle later", {31'b0, irq}, 32'h1);

      // R8 reset mid-operation
      @(negedge clk); rst_n = 1'b0;
      #1 check("R8 irq after reset", {31'b0, irq}, 32'h0);
      read_at(8'h08, d); check("R8 status after reset", d, 32'h0);
      read_at(8'h10, d); check("R8 mask after reset", d, 32'h0);

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

   initial begin
      repeat (5000) @(posedge clk);
      if (!done) begin
         n_vec++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end
endmodule